// File: doc/BRIEF.md
# External Interrupt Request Controller

This block turns one active-low external interrupt pin into a single request line for the CPU's interrupt priority logic. The pin goes through a two-flop synchronizer. A falling edge is a synchronized low sample whose previous sample was high. Each falling edge sets a pending flag. The flag is cleared by an acknowledge, which comes either from the CPU's vector fetch or from software writing a one to an acknowledge bit.

A mode bit selects how the pin is sensed:

- **Edge mode:** any acknowledge clears the flag at once.
- **Edge-plus-level mode:** a low pin also raises the flag and keeps it raised. The flag clears only after an acknowledge has been seen and the pin has returned high. These two events may happen in either order.

A mask bit stops the pending flag from reaching the request output but leaves the flag itself intact. One 8-bit status/control register sits behind a single-cycle synchronous bus port that decodes one address. A constant vector address output tells the CPU where the handler address is stored.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and `irq_req` is 0.
- R2: In edge mode (bit 0 = 0), a falling edge on `irq_pin_n` sets the pending flag. The flag is visible as register bit 3 and on `irq_req` within three clock edges of the pin change.
- R3: In edge mode, a one-cycle pulse on `vec_ack` clears the pending flag even while the pin is still low.
- R4: A write to the register address with bit 2 set acts as an acknowledge, the same as `vec_ack`. Bit 2 always reads as 0.
- R5: In level mode (bit 0 = 1), an acknowledge given while the pin is low leaves the flag set. The flag clears once the pin returns high.
- R6: In level mode, if the pin returns high first and no acknowledge has been given, the flag stays set. A later acknowledge clears it.
- R7: In level mode, a low pin sets the pending flag even without a falling edge.
- R8: Bit 1 (mask) set forces `irq_req` to 0 while bit 3 still shows the pending flag. Clearing the mask presents the request again.
- R9: When a falling edge and an acknowledge arrive in the same cycle, the flag remains set.
- R10: A software acknowledge does not affect later pin activity: the next falling edge sets the flag again.
- R11: Writes to bits 7..3 have no effect, and bits 7..4 read 0. Writes to any other address have no effect, and reads from any other address return 0x00.
- R12: Reset clears the pending flag and the mode bit even while the pin is held low. After reset is released, a pin that stays low does not set the flag.
- R13: `irq_vector` is constantly 0xFFFA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| vec_ack | input | 1 | Vector-fetch acknowledge pulse from the CPU |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, 0x00 off-address) |
| irq_req | output | 1 | Request to the interrupt priority logic |
| irq_vector | output | 16 | Fixed vector address |

## Verification
The hardest situation to reach is a falling edge and an acknowledge landing in the same cycle while the flag is already set. The edge only becomes visible after the synchronizer delay. The stimulus therefore drives the pin low just after a clock edge and raises `vec_ack` exactly two edges later, so the acknowledge falls in the one cycle where the edge detector fires. The level-mode clear ordering is also exercised both ways round, with the flag read back after each step.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_MODE = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_ACK  = 2;
  localparam int BIT_FLAG = 3;

  typedef struct packed {
    logic imask;
    logic mode;
  } irq_ctrl_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_hi,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev_hi;

  // Everything resets low so a pin held low across reset never looks like an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain   <= '0;
      prev_hi <= 1'b0;
    end else begin
      chain   <= {chain[STAGES-2:0], pin_n};
      prev_hi <= chain[STAGES-1];
    end
  end

  assign pin_hi = chain[STAGES-1];
  assign fall   = prev_hi & ~chain[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic fall,
  input  logic pin_hi,
  input  logic ack,
  output logic pending
);
  logic ack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      ack_seen <= 1'b0;
    end else if (fall) begin
      // A new edge outranks any acknowledge in the same cycle.
      pending  <= 1'b1;
      ack_seen <= 1'b0;
    end else if (mode) begin
      if (!pending) begin
        pending  <= ~pin_hi;
        ack_seen <= 1'b0;
      end else if ((ack | ack_seen) && pin_hi) begin
        pending  <= 1'b0;
        ack_seen <= 1'b0;
      end else if (ack) begin
        ack_seen <= 1'b1;
      end
    end else begin
      ack_seen <= 1'b0;
      if (ack) pending <= 1'b0;
    end
  end

  a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> pending);
  a_r3_edge_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && ack && !fall) |=> !pending);
  a_r5_level_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && pending && !pin_hi) |=> pending);
  a_r6_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && pending && pin_hi && ack && !fall) |=> !pending);
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              flag,
  output logic [REG_W-1:0]  rdata,
  output irq_ctrl_t         ctrl,
  output logic              sw_ack
);
  logic hit, wr_hit;
  logic unused_wbits;

  assign hit          = (addr == REG_ADDR);
  assign wr_hit       = sel & wr & hit;
  assign sw_ack       = wr_hit & wdata[BIT_ACK];
  assign unused_wbits = ^wdata[REG_W-1:BIT_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_hit) begin
      ctrl.mode  <= wdata[BIT_MODE];
      ctrl.imask <= wdata[BIT_MASK];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[BIT_MODE] = ctrl.mode;
      rdata[BIT_MASK] = ctrl.imask;
      rdata[BIT_FLAG] = flag;
    end
  end

  a_r11_ctrl_stable_off_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctrl));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irq_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h40,
  parameter int                SYNC_STAGES = 2,
  parameter logic [15:0]       VECTOR      = 16'hFFFA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_pin_n,
  input  logic              vec_ack,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_req,
  output logic [15:0]       irq_vector
);
  logic      pin_hi, fall, pending, sw_ack;
  irq_ctrl_t ctrl;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n), .pin_hi(pin_hi), .fall(fall)
  );

  irq_pend u_pend (
    .clk(clk), .rst_n(rst_n), .mode(ctrl.mode), .fall(fall), .pin_hi(pin_hi),
    .ack(vec_ack | sw_ack), .pending(pending)
  );

  irq_csr #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_csr (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .flag(pending), .rdata(bus_rdata), .ctrl(ctrl), .sw_ack(sw_ack)
  );

  assign irq_req    = pending & ~ctrl.imask;
  assign irq_vector = VECTOR;

  a_r8_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.imask |-> !irq_req);
  a_r12_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pending && !ctrl.mode));
endmodule

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/100ps
module ext_irq_ctrl_tb;
  localparam logic [7:0] REG_A = 8'h40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_pin_n = 1'b1;
  logic       vec_ack = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_addr = REG_A;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_req;
  logic [15:0] irq_vector;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string      tag;
    logic [7:0] rd;
    logic       req;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .vec_ack(vec_ack),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  // Monitor: pops one expected item per cycle and compares at the falling edge.
  always @(negedge clk) begin
    if (q.size() != 0) begin
      cur = q.pop_front();
      checks++;
      if (bus_rdata !== cur.rd || irq_req !== cur.req) begin
        fails++;
        $display("FAIL %s: rdata=%02h irq_req=%0b expected rdata=%02h irq_req=%0b",
                 cur.tag, bus_rdata, irq_req, cur.rd, cur.req);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expect_at(input string tag, input logic [7:0] a,
                           input logic [7:0] rd, input logic req);
    bus_addr = a;
    q.push_back('{tag, rd, req});
    tick();
    bus_addr = REG_A;
  endtask

  task automatic expect_st(input string tag, input logic [7:0] rd, input logic req);
    expect_at(tag, REG_A, rd, req);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = REG_A; bus_wdata = 8'h00;
  endtask

  task automatic pulse_ack();
    vec_ack = 1'b1;
    tick();
    vec_ack = 1'b0;
  endtask

  task automatic pin(input logic v);
    irq_pin_n = v;
    wait_n(4);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    expect_st("R1 reset state", 8'h00, 1'b0);
    checks++;
    if (irq_vector !== 16'hFFFA) begin
      fails++;
      $display("FAIL R13 vector: got %04h expected FFFA", irq_vector);
    end

    pin(1'b0);
    expect_st("R2 edge sets flag", 8'h08, 1'b1);
    pulse_ack();
    expect_st("R3 edge-mode vec ack clears while low", 8'h00, 1'b0);

    pin(1'b1); pin(1'b0);
    expect_st("R2 second edge", 8'h08, 1'b1);
    bus_write(REG_A, 8'h04);
    expect_st("R4 sw ack clears, ack bit reads 0", 8'h00, 1'b0);
    pin(1'b1); pin(1'b0);
    expect_st("R10 edge after sw ack sets flag", 8'h08, 1'b1);

    // R9: flag already set; align ack with the cycle the edge detector fires.
    pin(1'b1);
    expect_st("R9 precondition flag held", 8'h08, 1'b1);
    irq_pin_n = 1'b0;
    tick(); tick();
    vec_ack = 1'b1;
    tick();
    vec_ack = 1'b0;
    expect_st("R9 simultaneous edge and ack keeps flag", 8'h08, 1'b1);

    pulse_ack();
    expect_st("R3 clear before level test", 8'h00, 1'b0);
    bus_write(REG_A, 8'h01);
    tick();
    expect_st("R7 low level sets flag in level mode", 8'h09, 1'b1);
    pulse_ack();
    expect_st("R5 ack while low keeps flag", 8'h09, 1'b1);
    pin(1'b1);
    expect_st("R5 clears after pin high", 8'h01, 1'b0);

    pin(1'b0);
    pin(1'b1);
    expect_st("R6 pin high without ack keeps flag", 8'h09, 1'b1);
    bus_write(REG_A, 8'h05);
    expect_st("R6 ack after pin high clears", 8'h01, 1'b0);

    bus_write(REG_A, 8'h03);
    pin(1'b0);
    expect_st("R8 mask blocks request, flag visible", 8'h0B, 1'b0);
    bus_write(REG_A, 8'h01);
    expect_st("R8 unmask presents request", 8'h09, 1'b1);

    bus_write(REG_A, 8'hF3);
    expect_st("R11 upper bits ignored", 8'h0B, 1'b0);
    bus_write(8'h41, 8'h00);
    expect_st("R11 other address write ignored", 8'h0B, 1'b0);
    expect_at("R11 other address reads zero", 8'h41, 8'h00, 1'b0);

    rst_n = 1'b0;
    tick();
    expect_st("R12 reset with pin low", 8'h00, 1'b0);
    rst_n = 1'b1;
    wait_n(5);
    expect_st("R12 stays clear after reset, pin low", 8'h00, 1'b0);

    wait_n(2);
    summary();
    $finish;
  end
endmodule